// File: doc/BRIEF.md
# Lockable Victim Way Selector

This block picks which way of a 64-way associative cache receives the next linefill. It has two selection policies. In pseudo-random mode the victim comes from a free-running linear feedback shift register. In round-robin mode it comes from a pointer that steps once per linefill. A mode input switches between the two while the block runs, and reset always leaves it in pseudo-random mode.

A lock floor input reserves the lowest-numbered ways. A way whose index is below the floor is never offered as a victim, so data placed there survives every later linefill. Each step of the floor locks one more way, which is 1/64 of the cache.

The victim output is a combinational function of the registered state and the current floor. A cache controller can therefore read it in any cycle. It pulses the linefill strobe in the cycle it actually consumes the victim.

Top module: `way_victim_sel`

## Requirements
- R1: After reset is released, the registered mode is pseudo-random, the shift register holds 8'hA5 and the round-robin pointer holds 0. While reset is low, the output already reflects this state.
- R2: `rr_mode` = 1 selects round-robin and `rr_mode` = 0 selects pseudo-random. The input is registered at each clock edge, so a change first shows at the output in the cycle after the edge that samples it.
- R3: The 8-bit shift register steps on every clock edge out of reset, whatever the mode or strobe. The new bit 0 is the XOR of bits 7, 5, 4 and 3, and the other bits shift up by one. In pseudo-random mode the raw victim is bits 5:0 of the register.
- R4: In pseudo-random mode, a raw value below `lock_floor` is replaced by the bitwise OR of the raw value and `lock_floor`. A raw value at or above the floor is passed through unchanged.
- R5: In round-robin mode, each clock edge with `fill_stb` high moves the pointer up by one. From way 63 the pointer wraps to `lock_floor`. With no strobe, or in pseudo-random mode, an in-range pointer holds its value.
- R6: The victim is never below `lock_floor`. If the floor rises above the pointer, the round-robin output is the floor in that same cycle, and the stored pointer becomes the floor at the next edge.
- R7: With `lock_floor` = 63, the victim is 63 in every cycle and in both modes.
- R8: With `lock_floor` = 0, all 64 ways can be chosen, and round-robin visits 0 through 63 in order before it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 1 = round-robin, 0 = pseudo-random |
| lock_floor | input | 6 | Lowest way that may be replaced; ways below it are locked |
| fill_stb | input | 1 | Pulses in each cycle a linefill consumes the victim |
| victim_way | output | 6 | Way index to replace |

## Verification
The bench drives the round-robin pointer through its wrap at way 63. It does this with the floor at zero, where the pointer must return to 0, and with a raised floor, where it must return to the floor. A design that wrapped to zero would hand out locked ways. The bench raises the floor above a pointer that is already advanced, and it lets the shift register produce raw values under a raised floor. An off-by-one in either clamp or in the fold would show up as a victim below the floor. It also pins the floor at 63 in both modes and toggles the mode mid-run. A design that ignored the one-cycle mode register, or that stepped the shift register only on strobes, would drift away from the cycle-by-cycle model at once.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic {
        SEL_RANDOM = 1'b0,
        SEL_ROUND  = 1'b1
    } sel_mode_e;

endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_o
);

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[W-2:0], ^(st_q.sr & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sr: SEED};
        else        st_q <= st_d;
    end

    assign state_o = st_q.sr;

    // R3: a register that starts non-zero never reaches the all-zero lock-up state
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sr != '0);

    // R3: the register shifts on every edge
    a_r3_lfsr_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.sr[W-1:1] == $past(st_q.sr[W-2:0]));

endmodule

// File: rtl/vsel_rr_ptr.sv
module vsel_rr_ptr #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    input  logic [IDX_W-1:0] floor_i,
    output logic [IDX_W-1:0] cur_o
);

    localparam logic [IDX_W-1:0] LAST = '1;

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } rr_st_t;

    rr_st_t st_d, st_q;
    logic [IDX_W-1:0] clamped;

    always_comb begin
        clamped = (st_q.ptr < floor_i) ? floor_i : st_q.ptr;
        st_d    = st_q;
        if (advance_i) begin
            st_d.ptr = (clamped == LAST) ? floor_i : clamped + IDX_W'(1);
        end else begin
            st_d.ptr = clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ptr: '0};
        else        st_q <= st_d;
    end

    assign cur_o = clamped;

    // R5: an in-range pointer below the top steps by exactly one
    a_r5_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && st_q.ptr >= floor_i && st_q.ptr != LAST)
        |=> st_q.ptr == $past(st_q.ptr) + IDX_W'(1));

    // R5: the wrap from the top way lands on the floor
    a_r5_rr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && st_q.ptr == LAST) |=> st_q.ptr == $past(floor_i));

    // R5: without a strobe an in-range pointer holds
    a_r5_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && st_q.ptr >= floor_i) |=> $stable(st_q.ptr));

    // R6: a pointer left below a raised floor is pulled up to it
    a_r6_rr_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && st_q.ptr < floor_i) |=> st_q.ptr == $past(floor_i));

endmodule

// File: rtl/vsel_fold.sv
module vsel_fold #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] raw_i,
    input  logic [IDX_W-1:0] floor_i,
    output logic [IDX_W-1:0] way_o
);

    always_comb begin
        if (raw_i < floor_i) way_o = raw_i | floor_i;
        else                 way_o = raw_i;
    end

endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
    parameter int          WAYS   = 64,
    parameter int          LFSR_W = 8,
    parameter logic [7:0]  TAPS   = 8'hB8,
    parameter logic [7:0]  SEED   = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rr_mode,
    input  logic [5:0] lock_floor,
    input  logic       fill_stb,
    output logic [5:0] victim_way
);

    import vsel_pkg::*;

    localparam int IDX_W = $clog2(WAYS);
    localparam logic [IDX_W-1:0] TOP_WAY = IDX_W'(WAYS - 1);

    typedef struct packed {
        sel_mode_e mode;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [LFSR_W-1:0] lfsr_state;
    logic [IDX_W-1:0]  rr_way;
    logic [IDX_W-1:0]  rand_way;
    logic              rr_advance;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.mode = rr_mode ? SEL_ROUND : SEL_RANDOM;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: SEL_RANDOM};
        else        ctl_q <= ctl_d;
    end

    assign rr_advance = fill_stb && (ctl_q.mode == SEL_ROUND);

    vsel_lfsr #(
        .W    (LFSR_W),
        .TAPS (TAPS[LFSR_W-1:0]),
        .SEED (SEED[LFSR_W-1:0])
    ) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (lfsr_state)
    );

    vsel_rr_ptr #(
        .IDX_W (IDX_W)
    ) i_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (rr_advance),
        .floor_i   (lock_floor),
        .cur_o     (rr_way)
    );

    vsel_fold #(
        .IDX_W (IDX_W)
    ) i_fold (
        .raw_i   (lfsr_state[IDX_W-1:0]),
        .floor_i (lock_floor),
        .way_o   (rand_way)
    );

    assign victim_way = (ctl_q.mode == SEL_ROUND) ? rr_way : rand_way;

    // R6: no locked way is ever offered
    a_r6_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
        victim_way >= lock_floor);

    // R7: a floor at the top leaves a single candidate
    a_r7_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        lock_floor == TOP_WAY |-> victim_way == TOP_WAY);

    // R2: the mode seen by the output follows the input one edge later
    a_r2_mode_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctl_q.mode == SEL_ROUND) == $past(rr_mode));

endmodule

// File: tb/test_way_victim_sel.sv
module test_way_victim_sel;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rr_mode = 1'b0;
    logic [5:0] lock_floor = '0;
    logic       fill_stb = 1'b0;
    logic [5:0] victim_way;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_mode;
    int m_lfsr;
    int m_rr;
    int stb_pat;
    int cyc_no = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    way_victim_sel i_way_victim_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .rr_mode    (rr_mode),
        .lock_floor (lock_floor),
        .fill_stb   (fill_stb),
        .victim_way (victim_way)
    );

    function automatic int expect_way();
        int base = int'(lock_floor);
        int raw;
        if (m_mode == 1) begin
            raw = (m_rr < base) ? base : m_rr;
        end else begin
            raw = m_lfsr & 63;
            if (raw < base) raw = raw | base;
        end
        return raw;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: cycle %0d victim=%0d expected=%0d", tag, cyc_no, got, exp);
        end
    endtask

    task automatic model_step();
        int base = int'(lock_floor);
        int fb;
        int cur;
        if (m_mode == 1 && fill_stb) begin
            cur = (m_rr < base) ? base : m_rr;
            m_rr = (cur == 63) ? base : cur + 1;
        end else if (m_rr < base) begin
            m_rr = base;
        end
        fb = ((m_lfsr >> 7) ^ (m_lfsr >> 5) ^ (m_lfsr >> 4) ^ (m_lfsr >> 3)) & 1;
        m_lfsr = ((m_lfsr << 1) | fb) & 255;
        m_mode = rr_mode ? 1 : 0;
    endtask

    // Runs n cycles; entered and left just after a falling edge.
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            case (stb_pat)
                0: fill_stb = 1'b0;
                1: fill_stb = 1'b1;
                default: fill_stb = (cyc_no % 3) == 0;
            endcase
            #(CLK_PERIOD / 4);
            check(tag, int'(victim_way), expect_way());
            if (int'(victim_way) < int'(lock_floor))
                check("R6", int'(victim_way), int'(lock_floor));
            @(posedge clk);
            #1;
            if (rst_n) model_step();
            cyc_no++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_lfsr = 8'hA5; m_rr = 0; stb_pat = 0;
        @(negedge clk);
        // R1: state visible while reset is held
        run(3, "R1");
        rst_n = 1'b1;
        run(1, "R1");

        // R3/R4: pseudo-random, floor 0, then raised floors
        stb_pat = 2;
        run(40, "R3");
        lock_floor = 6'd40;
        run(40, "R4");
        lock_floor = 6'd5;
        run(20, "R4");

        // R8: round-robin with floor 0, full sweep and wrap to 0
        lock_floor = 6'd0;
        rr_mode = 1'b1;
        stb_pat = 1;
        run(1, "R2");
        run(140, "R8");

        // R5: holds without strobe, steps every third cycle
        stb_pat = 0;
        run(5, "R5");
        stb_pat = 2;
        run(30, "R5");

        // R6: floor raised above the pointer, then wrap to floor
        stb_pat = 0;
        lock_floor = 6'd50;
        run(3, "R6");
        stb_pat = 1;
        run(40, "R5");

        // R2: mode toggles mid-run
        rr_mode = 1'b0;
        run(4, "R2");
        rr_mode = 1'b1;
        run(4, "R2");

        // R7: single unlocked way in both modes
        lock_floor = 6'd63;
        run(20, "R7");
        rr_mode = 1'b0;
        run(30, "R7");

        // R6: floor dropped again, pointer free to sweep the lower range
        lock_floor = 6'd10;
        rr_mode = 1'b1;
        run(70, "R6");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule